// File: doc/BRIEF.md
# Processor Reset Exit Sequencer

This block governs a small processor core around reset. While the reset pin is held, it tells the core to load defined reset values into the status register and the operating mode register. When the pin is released, it latches the chip operating mode from two external mode-select pins and the cause of the reset, which is either the hardware pin or a watchdog time-out. It then idles the core through a fixed synchronisation delay and presents the first program fetch address. That address is taken from a parameterised table indexed by the mode bits and the reset cause.

The reset pin is synchronised to the machine clock before use. All timing is counted in machine cycles, and two machine cycles make one instruction cycle. After the delay, `run_en` lets the pipeline fetch from `start_vec`. Two instruction cycles later, `exec_en` marks the point where the first fetched instruction, now decoded, can execute.

Top module: `rst_exit_seq`

## Requirements
- R1: While `reg_load` is high, `sr_init` (bit 6 loop flag, bits 5:4 interrupt mask, bits 3:0 condition codes) reads 7'b0110000 from the next cycle on: the loop flag and condition codes are clear and both mask bits are set.
- R2: Bits 6:2 of `omr_init` (nested looping, condition-code mode, stop delay, rounding, external X memory) read zero while `reg_load` is high and stay zero through the exit sequence.
- R3: `reg_load` stays high while the synchronised reset is active. After `rst_pin_n` rises, `reg_load` is still high following the second rising clock edge and drops after the third.
- R4: `omr_init[1:0]` (bit 0 = MA from `mode_sel[0]`, bit 1 = MB from `mode_sel[1]`) takes the value of `mode_sel` sampled at the fourth rising edge after release. Later changes of `mode_sel` have no effect until the next reset.
- R5: `run_en` rises exactly 2*DELAY_ICYC machine cycles after the mode capture edge, which is the 36th edge after release with the default of 16 instruction cycles.
- R6: While `run_en` is high, `start_vec` is the table entry at index {wdog_reset, MB, MA}, with entry i held in bits [i*AW +: AW] of VEC_TABLE. The reset cause is sampled at the same edge as the mode. While `run_en` is low, `start_vec` is zero.
- R7: `exec_en` rises exactly four machine cycles (two instruction cycles) after `run_en` rises, and it is never high without `run_en`.
- R8: Driving `rst_pin_n` low at any point of the sequence brings `reg_load` high and `run_en`, `exec_en` and `start_vec` low by the third rising edge. A new release restarts the whole sequence.
- R9: While reset is held, changes of `mode_sel` and `wdog_reset` have no effect: `omr_init[1:0]` stays zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Machine clock |
| rst_pin_n | input | 1 | Asynchronous reset pin, active low |
| mode_sel | input | 2 | Mode-select pins, bit 0 MA, bit 1 MB |
| wdog_reset | input | 1 | Reset cause: 1 watchdog time-out, 0 hardware pin |
| sr_init | output | 7 | Status register value for the core to load |
| omr_init | output | 7 | Operating mode register value for the core to load |
| reg_load | output | 1 | Core loads `sr_init`/`omr_init` while high |
| start_vec | output | AW | First fetch address, valid with `run_en` |
| run_en | output | 1 | Pipeline may fetch |
| exec_en | output | 1 | First instruction may execute |

## Verification
The bench builds the block with the default 16-instruction-cycle delay and 16-bit addresses, so the 36-edge release-to-run and 40-edge release-to-execute timing is checked as specified. It overrides VEC_TABLE with eight distinct, non-default addresses, so a wrong index bit order or a swapped reset cause selects a visibly wrong entry. It walks all four mode combinations under both reset causes, and it re-asserts the pin during the delay and during run.

// File: rtl/rse_pkg.sv
// Package: shared state type, register layouts and reset constants for the
// reset exit sequencer. Assumes a 7-bit status and mode register view.
package rse_pkg;

    typedef enum logic [1:0] {
        ST_RESET   = 2'd0,
        ST_CAPTURE = 2'd1,
        ST_DELAY   = 2'd2,
        ST_RUN     = 2'd3
    } seq_state_t;

    localparam int SR_W  = 7;
    localparam int OMR_W = 7;

    // status view: [6] loop flag, [5:4] interrupt mask, [3:0] condition codes
    localparam logic [SR_W-1:0] SR_RST_VAL = 7'b011_0000;

    // mode view: [1:0] MB,MA ; [6:2] flags that reset clears
    localparam int OMR_MODE_LSB = 0;
    localparam int OMR_MODE_W   = 2;
    localparam logic [OMR_W-OMR_MODE_W-1:0] OMR_FLAGS_RST = '0;

endpackage

// File: rtl/rse_sync.sv
// Module: two-or-more stage synchroniser for the asynchronous reset pin.
// Assumes the pin is glitch free; release reaches the output after STAGES edges.
module rse_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic pin_n,
    output logic sync_n
);

    logic [STAGES-1:0] chain;

    // shift the pin level through the synchroniser chain
    always_ff @(posedge clk) begin
        chain <= {chain[STAGES-2:0], pin_n};
    end

    assign sync_n = chain[STAGES-1];

endmodule

// File: rtl/rse_fsm.sv
// Module: exit sequence controller. Walks reset, capture, delay and run, and
// times the first-execute point. Assumes rst_n is already synchronised.
module rse_fsm
    import rse_pkg::*;
#(
    parameter int DELAY_ICYC     = 16,
    parameter int MC_PER_IC      = 2,
    parameter int FETCH_EXEC_IC  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    output seq_state_t state,
    output logic       capture,
    output logic       run_en,
    output logic       exec_en
);

    localparam int DELAY_MC = DELAY_ICYC * MC_PER_IC;
    localparam int CW       = $clog2(DELAY_MC + 1);
    localparam int EXEC_MC  = FETCH_EXEC_IC * MC_PER_IC;
    localparam int EW       = $clog2(EXEC_MC + 1);
    localparam logic [CW-1:0] DLY_LAST = CW'(DELAY_MC - 1);
    localparam logic [EW-1:0] EXE_LAST = EW'(EXEC_MC);

    logic [CW-1:0] dly_cnt;
    logic [EW-1:0] exe_cnt;

    // state register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_RESET;
        end else begin
            unique case (state)
                ST_RESET:   state <= ST_CAPTURE;
                ST_CAPTURE: state <= ST_DELAY;
                ST_DELAY:   if (dly_cnt == DLY_LAST) state <= ST_RUN;
                default:    state <= ST_RUN;
            endcase
        end
    end

    // synchronisation delay counter, machine cycles
    always_ff @(posedge clk) begin
        if (!rst_n || state != ST_DELAY) dly_cnt <= '0;
        else                             dly_cnt <= dly_cnt + 1'b1;
    end

    // fetch-to-execute counter, saturates at the execute point
    always_ff @(posedge clk) begin
        if (!rst_n || state != ST_RUN) exe_cnt <= '0;
        else if (exe_cnt != EXE_LAST)  exe_cnt <= exe_cnt + 1'b1;
    end

    assign capture = (state == ST_CAPTURE);
    assign run_en  = (state == ST_RUN);
    assign exec_en = run_en && (exe_cnt == EXE_LAST);

    AST_DELAY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_en) |-> ($past(state) == ST_DELAY && $past(dly_cnt) == DLY_LAST)); // R5
    AST_RESET_ENTRY: assert property (@(posedge clk)
        !rst_n |=> state == ST_RESET); // R8
    AST_CAPTURE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> !capture); // R4

endmodule

// File: rtl/rse_regs.sv
// Module: register value generator. Drives status and mode register values
// for the core to load, latching the mode pins once per reset exit.
module rse_regs
    import rse_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic                  capture,
    input  logic [OMR_MODE_W-1:0] mode_pins,
    output logic [SR_W-1:0]       sr_val,
    output logic [OMR_W-1:0]      omr_val
);

    logic [SR_W-1:0]       sr_q;
    logic [OMR_MODE_W-1:0] mode_q;

    // status register reset image
    always_ff @(posedge clk) begin
        if (!rst_n || load) sr_q <= SR_RST_VAL;
    end

    // mode bits: cleared in reset, loaded from the pins at capture
    always_ff @(posedge clk) begin
        if (!rst_n || load) mode_q <= '0;
        else if (capture)   mode_q <= mode_pins;
    end

    assign sr_val  = sr_q;
    assign omr_val = {OMR_FLAGS_RST, mode_q};

    AST_SR_RESET_IMAGE: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> sr_val == SR_RST_VAL); // R1
    AST_MODE_CLEAR_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        load && $past(load) |-> omr_val[OMR_MODE_W-1:0] == '0); // R9
    AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !capture && !load && !$past(load) |=> $stable(mode_q)); // R4

endmodule

// File: rtl/rse_vecsel.sv
// Module: start vector selector. Latches {cause, MB, MA} at capture and looks
// the address up in a packed parameter table of eight entries.
module rse_vecsel #(
    parameter int                AW        = 16,
    parameter logic [8*AW-1:0]   VEC_TABLE = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  logic [1:0]    mode_pins,
    input  logic          cause_wd,
    input  logic          run_en,
    output logic [AW-1:0] start_vec
);

    localparam int N_ENT = 8;
    localparam int IW    = $clog2(N_ENT);

    logic [AW-1:0] table_e [N_ENT];
    logic [IW-1:0] idx_q;

    genvar g;
    generate
        for (g = 0; g < N_ENT; g++) begin : g_unpack
            assign table_e[g] = VEC_TABLE[g*AW +: AW];
        end
    endgenerate

    // latch table index alongside the mode capture
    always_ff @(posedge clk) begin
        if (!rst_n)       idx_q <= '0;
        else if (capture) idx_q <= {cause_wd, mode_pins};
    end

    assign start_vec = run_en ? table_e[idx_q] : '0;

    AST_VEC_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |-> start_vec == '0); // R6
    AST_VEC_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        run_en && $past(run_en) |-> $stable(start_vec)); // R6

endmodule

// File: rtl/rst_exit_seq.sv
// Module: top of the reset exit sequencer. Synchronises the reset pin, drives
// register reset values, captures mode and cause, waits the delay and
// releases the pipeline with its first fetch address.
module rst_exit_seq
    import rse_pkg::*;
#(
    parameter int              AW          = 16,
    parameter int              DELAY_ICYC  = 16,
    parameter int              SYNC_STAGES = 2,
    parameter logic [8*AW-1:0] VEC_TABLE   = {16'h7002, 16'h5002, 16'h3002, 16'h1002,
                                              16'h6000, 16'h4000, 16'h2000, 16'h0000}
) (
    input  logic          clk,
    input  logic          rst_pin_n,
    input  logic [1:0]    mode_sel,
    input  logic          wdog_reset,
    output logic [6:0]    sr_init,
    output logic [6:0]    omr_init,
    output logic          reg_load,
    output logic [AW-1:0] start_vec,
    output logic          run_en,
    output logic          exec_en
);

    logic       rst_s_n;
    logic       capture;
    seq_state_t state;

    rse_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .pin_n  (rst_pin_n),
        .sync_n (rst_s_n)
    );

    rse_fsm #(.DELAY_ICYC(DELAY_ICYC), .MC_PER_IC(2), .FETCH_EXEC_IC(2)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_s_n),
        .state   (state),
        .capture (capture),
        .run_en  (run_en),
        .exec_en (exec_en)
    );

    assign reg_load = (state == ST_RESET);

    rse_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_s_n),
        .load      (reg_load),
        .capture   (capture),
        .mode_pins (mode_sel),
        .sr_val    (sr_init),
        .omr_val   (omr_init)
    );

    rse_vecsel #(.AW(AW), .VEC_TABLE(VEC_TABLE)) u_vec (
        .clk       (clk),
        .rst_n     (rst_s_n),
        .capture   (capture),
        .mode_pins (mode_sel),
        .cause_wd  (wdog_reset),
        .run_en    (run_en),
        .start_vec (start_vec)
    );

    AST_EXEC_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_s_n)
        exec_en |-> run_en); // R7
    AST_FLAGS_CLEAR: assert property (@(posedge clk) disable iff (!rst_s_n)
        !reg_load |-> omr_init[6:2] == '0); // R2
    AST_NO_RUN_IN_LOAD: assert property (@(posedge clk) disable iff (!rst_s_n)
        reg_load |-> !run_en && !exec_en); // R3

endmodule

// File: tb/sim_rst_exit_seq.sv
module sim_rst_exit_seq;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam logic [8*AW-1:0] TB_TABLE = {16'hF0C3, 16'hE0B2, 16'hD0A1, 16'hC090,
                                            16'h4433, 16'h3322, 16'h2211, 16'h1100};
    // {cause, mode[1:0], expected start address}
    localparam logic [18:0] VECS [8] = '{
        {1'b0, 2'd0, 16'h1100}, {1'b0, 2'd1, 16'h2211},
        {1'b0, 2'd2, 16'h3322}, {1'b0, 2'd3, 16'h4433},
        {1'b1, 2'd0, 16'hC090}, {1'b1, 2'd1, 16'hD0A1},
        {1'b1, 2'd2, 16'hE0B2}, {1'b1, 2'd3, 16'hF0C3}
    };

    logic          clk = 0;
    logic          rst_pin_n;
    logic [1:0]    mode_sel;
    logic          wdog_reset;
    logic [6:0]    sr_init, omr_init;
    logic          reg_load, run_en, exec_en;
    logic [AW-1:0] start_vec;
    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rst_exit_seq #(.AW(AW), .VEC_TABLE(TB_TABLE)) u0 (
        .clk(clk), .rst_pin_n(rst_pin_n), .mode_sel(mode_sel), .wdog_reset(wdog_reset),
        .sr_init(sr_init), .omr_init(omr_init), .reg_load(reg_load),
        .start_vec(start_vec), .run_en(run_en), .exec_en(exec_en)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic hold_reset(input int n);
        rst_pin_n = 0;
        tick(n);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_pin_n = 0; mode_sel = 2'd0; wdog_reset = 0;
        tick(6);
        // reset state
        chk("R1 sr reset image", 32'(sr_init), 32'h30);
        chk("R2 omr reset image", 32'(omr_init), 32'h0);
        chk("R3 load in reset", 32'(reg_load), 32'h1);
        chk("R8 idle outputs", 32'({run_en, exec_en, start_vec}), 32'h0);

        // table walk over all mode and cause combinations
        for (int i = 0; i < 8; i++) begin
            logic [1:0] m;
            logic       c;
            m = VECS[i][17:16];
            c = VECS[i][18];
            mode_sel = m; wdog_reset = c;
            hold_reset(4);
            rst_pin_n = 1;
            tick(2);
            chk("R3 load after edge 2", 32'(reg_load), 32'h1);
            tick(1);
            chk("R3 load drops at edge 3", 32'(reg_load), 32'h0);
            chk("R4 mode not yet captured", 32'(omr_init[1:0]), 32'h0);
            tick(1);
            mode_sel = ~m; wdog_reset = ~c;   // later changes must be ignored
            tick(31);
            chk("R5 run low at edge 35", 32'(run_en), 32'h0);
            tick(1);
            chk("R5 run high at edge 36", 32'(run_en), 32'h1);
            chk("R6 start vector", 32'(start_vec), 32'(VECS[i][15:0]));
            chk("R4 captured mode", 32'(omr_init[1:0]), 32'(m));
            chk("R2 flags stay clear", 32'(omr_init[6:2]), 32'h0);
            chk("R1 sr kept", 32'(sr_init), 32'h30);
            tick(3);
            chk("R7 exec low at edge 39", 32'(exec_en), 32'h0);
            tick(1);
            chk("R7 exec high at edge 40", 32'(exec_en), 32'h1);
        end

        // reassert during run
        rst_pin_n = 0;
        tick(3);
        chk("R8 run reassert", 32'({reg_load, run_en, exec_en, start_vec}), 32'h1_0000 << 2);

        // pins ignored while held
        mode_sel = 2'd3; wdog_reset = 1;
        tick(3);
        mode_sel = 2'd2;
        tick(2);
        chk("R9 mode ignored in reset", 32'(omr_init[1:0]), 32'h0);
        chk("R1 sr during hold", 32'(sr_init), 32'h30);

        // reassert in the middle of the delay, then a clean restart
        mode_sel = 2'd1; wdog_reset = 0;
        rst_pin_n = 1;
        tick(12);
        rst_pin_n = 0;
        tick(3);
        chk("R8 delay reassert load", 32'(reg_load), 32'h1);
        chk("R8 delay reassert run", 32'(run_en), 32'h0);
        mode_sel = 2'd2; wdog_reset = 1;
        tick(2);
        rst_pin_n = 1;
        tick(35);
        chk("R8 restart full delay", 32'(run_en), 32'h0);
        tick(1);
        chk("R8 restart run", 32'(run_en), 32'h1);
        chk("R6 restart vector", 32'(start_vec), 32'hE0B2);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule